// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block sequences one shared analogue-to-digital converter that sits behind an eight-input analogue multiplexer. It derives a slow converter clock from the system clock and issues a one-cycle sample strobe plus one step strobe per converter clock. It holds the multiplexer select steady for the whole conversion. When the last step arrives, it captures the converter's data word into a result register kept for that channel.

A conversion can start in three ways. Software can start one at once. A synchronised edge on one of six external trigger lines can start one. In burst mode, conversions run back to back and walk through the set bits of a channel mask. In burst mode a length code trades converter clocks against result precision. Each channel has its own result register and done flag, and an interrupt request stays high while any done flag is set. A power-down input stops any new conversion from starting.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `adc_sample`, `irq` and every bit of `done_flags` are 0, and every result register reads 0.
- R2: The converter clock (`adc_step`) is active once every `div_val`+1 system clocks during a conversion, and a `div_val` of 0 divides by one. A conversion of N converter clocks keeps `busy` high for exactly N*(`div_val`+1) system cycles.
- R3: With `burst_en` low, `start_code` 3'b000 starts nothing. A change of `start_code` to 3'b001 starts one conversion in the next cycle, on the lowest-numbered set mask channel. That conversion takes 11 converter clocks and stores all 10 data bits.
- R4: With `burst_en` low, `start_code` values 3'b010 to 3'b111 select trigger line `trig_in[start_code-2]`. `edge_fall`=0 selects a rising edge and `edge_fall`=1 selects a falling edge. `busy` rises on the third clock edge after the line changes (two synchroniser flops, then edge detection). Edges on other lines, and edges of the other polarity, start nothing.
- R5: In burst mode, `len_code` c (0 to 7) gives 11-c converter clocks per conversion and 10-c result bits. The stored value is `adc_data` shifted right by c, so it is right-aligned with the upper bits zero.
- R6: In burst mode, conversions follow each other with no idle cycle. The first uses the lowest set bit of `chan_mask`, each later one uses the next higher set bit, and the scan wraps from the highest set bit back to the lowest.
- R7: A `chan_mask` of all zeros behaves as if only channel 0 were selected.
- R8: Clearing `burst_en` during a conversion lets that conversion finish and store its result. No further conversion starts.
- R9: While `pwr_down` is high, no conversion starts from software, a trigger or burst. An edge seen during power-down is not kept for later.
- R10: Each channel has its own result register. Storing a result sets that channel's bit of `done_flags`. A read (`rd_en` with `rd_chan`) returns the register on `rd_data` and clears that flag. `irq` is high while any done flag is set.
- R11: `busy` is high from the cycle after the start decision until the result is stored. `adc_sample` pulses in the first cycle of every conversion, and `adc_chan` does not change within a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Converter clock divider; the period is div_val+1 system clocks |
| chan_mask | input | 8 | Channel-select mask; all zeros means channel 0 |
| burst_en | input | 1 | Repeated scanning conversions when high |
| len_code | input | 3 | Burst conversion length and precision code |
| start_code | input | 3 | Start source when not bursting |
| edge_fall | input | 1 | Trigger edge: 1 falling, 0 rising |
| pwr_down | input | 1 | Blocks all conversion starts |
| trig_in | input | 6 | Asynchronous external trigger lines |
| adc_data | input | 10 | Data word from the converter |
| adc_sample | output | 1 | One-cycle sample strobe at the start of a conversion |
| adc_step | output | 1 | Converter clock strobe during a conversion |
| adc_chan | output | 3 | Multiplexer channel select |
| busy | output | 1 | Conversion in progress |
| rd_en | input | 1 | Read strobe for a result register |
| rd_chan | input | 3 | Channel to read |
| rd_data | output | 10 | Result register of rd_chan |
| done_flags | output | 8 | Per-channel result-ready flags |
| irq | output | 1 | Interrupt request: any done flag set |

## Verification
The hardest case to reach is burst termination, where `burst_en` is cleared in the middle of a conversion that has wrapped back to the first channel. The bench watches `adc_sample` and logs the channel at each strobe. On the strobe that starts the wrapped-around conversion, it clears that channel's done flag with a read and then drops `burst_en`. It then checks that the flag is set again by the finishing conversion, at the reduced precision, and that no sample strobe follows. Power-down uses a similar approach: the bench creates software, trigger and burst start conditions while `pwr_down` is high, then checks that none of them starts a conversion after power-down is released.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;

  localparam int unsigned START_W = 3;
  localparam logic [START_W-1:0] START_NONE  = 3'd0;
  localparam logic [START_W-1:0] START_NOW   = 3'd1;
  localparam int unsigned        TRIG_BASE   = 2;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int unsigned DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [DIVW-1:0] div_val,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == div_val) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == div_val);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0) |=> (!tick || div_val == '0)); // R2

endmodule

// File: rtl/adc_seq_trigsync.sv
module adc_seq_trigsync #(
  parameter int unsigned NTRIG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             edge_fall,
  output logic [NTRIG-1:0] trig_ev
);

  logic [NTRIG-1:0] meta_q, sync_q, hist_q;

  for (genvar t = 0; t < NTRIG; t++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[t] <= 1'b0;
        sync_q[t] <= 1'b0;
        hist_q[t] <= 1'b0;
      end else begin
        meta_q[t] <= trig_in[t];
        sync_q[t] <= meta_q[t];
        hist_q[t] <= sync_q[t];
      end
    end

    always_comb begin
      if (edge_fall) trig_ev[t] = hist_q[t] & ~sync_q[t];
      else           trig_ev[t] = ~hist_q[t] & sync_q[t];
    end
  end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned RESW = 10,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CHW-1:0]  wr_ch,
  input  logic [RESW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [CHW-1:0]  rd_chan,
  output logic [RESW-1:0] rd_data,
  output logic [NCH-1:0]  done_flags
);

  logic [RESW-1:0] res_q [NCH];
  logic [NCH-1:0]  done_q, done_d;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit_wr, hit_rd;
    assign hit_wr = wr_en && (wr_ch == CHW'(c));
    assign hit_rd = rd_en && (rd_chan == CHW'(c));

    always_comb begin
      done_d[c] = done_q[c];
      if (hit_wr)      done_d[c] = 1'b1;
      else if (hit_rd) done_d[c] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[c] <= '0;
      end else if (hit_wr) begin
        res_q[c] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= done_d;
  end

  assign rd_data    = res_q[rd_chan];
  assign done_flags = done_q;

  AST_DONE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done_q[$past(wr_ch)]); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && wr_ch == rd_chan)) |=> !done_q[$past(rd_chan)]); // R10

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned NTRIG = 6,
  parameter int unsigned DIVW  = 8,
  parameter int unsigned RESW  = 10,
  parameter int unsigned LENW  = 3,
  localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned STEPW = $clog2(RESW + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIVW-1:0]  div_val,
  input  logic [NCH-1:0]   chan_mask,
  input  logic             burst_en,
  input  logic [LENW-1:0]  len_code,
  input  logic [START_W-1:0] start_code,
  input  logic             edge_fall,
  input  logic             pwr_down,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [RESW-1:0]  adc_data,
  output logic             adc_sample,
  output logic             adc_step,
  output logic [CHW-1:0]   adc_chan,
  output logic             busy,
  input  logic             rd_en,
  input  logic [CHW-1:0]   rd_chan,
  output logic [RESW-1:0]  rd_data,
  output logic [NCH-1:0]   done_flags,
  output logic             irq
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) r = CHW'(i);
    end
    return r;
  endfunction

  function automatic logic [CHW-1:0] next_after(input logic [NCH-1:0] m,
                                                input logic [CHW-1:0] from);
    logic [CHW-1:0] r;
    logic found;
    r = lowest_set(m);
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && m[i] && (i > int'(from))) begin
        r = CHW'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  seq_state_e         state_q, state_d;
  logic [CHW-1:0]     chan_q, chan_d;
  logic [LENW-1:0]    shift_q, shift_d;
  logic [STEPW-1:0]   step_q, step_d;
  logic               sample_q;
  logic               fresh_q, fresh_d;
  logic [START_W-1:0] prev_code_q;

  logic [NCH-1:0]     mask_eff;
  logic [NTRIG-1:0]   trig_ev;
  logic               tick, idle, go_now, trig_hit;
  logic               start_idle, finish, chain, launch;
  logic [STEPW-1:0]   len_ticks;
  logic [RESW-1:0]    store_data;

  assign mask_eff  = (chan_mask == '0) ? NCH'(1) : chan_mask;
  assign idle      = (state_q == SEQ_IDLE);
  assign len_ticks = STEPW'(RESW + 1) - STEPW'(shift_q);
  assign go_now    = (start_code == START_NOW) && (prev_code_q != START_NOW);

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NTRIG; i++) begin
      if (start_code == START_W'(i + TRIG_BASE)) trig_hit = trig_hit | trig_ev[i];
    end
  end

  assign start_idle = idle && !pwr_down && (burst_en || go_now || trig_hit);
  assign finish     = !idle && tick && (step_q == len_ticks - 1'b1);
  assign chain      = finish && burst_en && !pwr_down;
  assign launch     = start_idle || chain;
  assign store_data = adc_data >> shift_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    shift_d = shift_q;
    step_d  = step_q;
    fresh_d = fresh_q;

    if (idle && !burst_en) fresh_d = 1'b1;

    if (launch) begin
      state_d = SEQ_CONV;
      step_d  = '0;
      if (burst_en) begin
        shift_d = len_code;
        chan_d  = fresh_q ? lowest_set(mask_eff) : next_after(mask_eff, chan_q);
        fresh_d = 1'b0;
      end else begin
        shift_d = '0;
        chan_d  = lowest_set(mask_eff);
      end
    end else if (finish) begin
      state_d = SEQ_IDLE;
    end else if (!idle && tick) begin
      step_d = step_q + 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= SEQ_IDLE;
      chan_q      <= '0;
      shift_q     <= '0;
      step_q      <= '0;
      sample_q    <= 1'b0;
      fresh_q     <= 1'b1;
      prev_code_q <= START_NONE;
    end else begin
      state_q     <= state_d;
      chan_q      <= chan_d;
      shift_q     <= shift_d;
      step_q      <= step_d;
      sample_q    <= launch;
      fresh_q     <= fresh_d;
      prev_code_q <= start_code;
    end
  end

  adc_seq_clkdiv #(.DIVW(DIVW)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (!idle),
    .clr     (launch),
    .div_val (div_val),
    .tick    (tick)
  );

  adc_seq_trigsync #(.NTRIG(NTRIG)) u_trig (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trig_in   (trig_in),
    .edge_fall (edge_fall),
    .trig_ev   (trig_ev)
  );

  adc_seq_results #(.NCH(NCH), .RESW(RESW)) u_res (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (finish),
    .wr_ch      (chan_q),
    .wr_data    (store_data),
    .rd_en      (rd_en),
    .rd_chan    (rd_chan),
    .rd_data    (rd_data),
    .done_flags (done_flags)
  );

  assign busy       = !idle;
  assign adc_sample = sample_q;
  assign adc_step   = tick;
  assign adc_chan   = chan_q;
  assign irq        = |done_flags;

  AST_PD_NO_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && pwr_down) |=> !busy); // R9
  AST_SAMPLE_AT_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> adc_sample); // R11
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy) && !adc_sample) |-> $stable(adc_chan)); // R11
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> (step_q < len_ticks)); // R5

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_val;
  logic [7:0]  chan_mask;
  logic        burst_en;
  logic [2:0]  len_code;
  logic [2:0]  start_code;
  logic        edge_fall;
  logic        pwr_down;
  logic [5:0]  trig_in;
  logic [9:0]  adc_data;
  logic        adc_sample, adc_step, busy, irq, rd_en;
  logic [2:0]  adc_chan, rd_chan;
  logic [9:0]  rd_data;
  logic [7:0]  done_flags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [9:0] stub_val(input int ch);
    return 10'((ch * 97 + 301) & 1023);
  endfunction

  // Behavioural converter: data word depends on the selected input.
  assign adc_data = stub_val(int'(adc_chan));

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .chan_mask(chan_mask),
    .burst_en(burst_en), .len_code(len_code), .start_code(start_code),
    .edge_fall(edge_fall), .pwr_down(pwr_down), .trig_in(trig_in),
    .adc_data(adc_data), .adc_sample(adc_sample), .adc_step(adc_step),
    .adc_chan(adc_chan), .busy(busy), .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_data(rd_data), .done_flags(done_flags), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_clear(input int ch);
    rd_chan = 3'(ch);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Waits for busy, then measures the conversion at the ports.
  task automatic measure(output int len, output int steps, output int ch,
                         output int samp);
    int guard = 0;
    len = 0; steps = 0; ch = -1; samp = 0;
    while (!busy && guard < 40) begin @(negedge clk); guard++; end
    ch = int'(adc_chan);
    samp = int'(adc_sample);
    while (busy && len < 5000) begin
      len++;
      if (adc_step) steps++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done_flags after reset", int'(done_flags), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 sample strobe after reset", int'(adc_sample), 0);
    rd_chan = 3'd5;
    @(negedge clk);
    chk("R1 result register after reset", int'(rd_data), 0);
  endtask

  task automatic t_software;
    int len, steps, ch, samp, seen;
    div_val = 8'd2; chan_mask = 8'h08; start_code = 3'b000;
    seen = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R3 code 000 starts nothing", seen, 0);
    start_code = 3'b001;
    @(negedge clk);
    chk("R3 busy in cycle after start", int'(busy), 1);
    measure(len, steps, ch, samp);
    chk("R2 busy length 11*(2+1)", len, 33);
    chk("R3 eleven converter clocks", steps, 11);
    chk("R11 sample strobe on first busy cycle", samp, 1);
    chk("R3 lowest set channel", ch, 3);
    chk("R10 done flag set", int'(done_flags), 8'h08);
    chk("R10 irq raised", int'(irq), 1);
    rd_chan = 3'd3;
    @(negedge clk);
    chk("R3 full 10-bit result", int'(rd_data), int'(stub_val(3)));
    read_clear(3);
    chk("R10 read clears flag", int'(done_flags), 0);
    chk("R10 irq drops", int'(irq), 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R3 code held at 001 starts only once", seen, 0);
    start_code = 3'b000;
    @(negedge clk);
  endtask

  task automatic t_div0;
    int len, steps, ch, samp;
    div_val = 8'd0; chan_mask = 8'h10;
    start_code = 3'b001;
    @(negedge clk);
    measure(len, steps, ch, samp);
    chk("R2 divide by one length", len, 11);
    chk("R2 step every cycle", steps, 11);
    read_clear(4);
    start_code = 3'b000;
    @(negedge clk);
  endtask

  task automatic t_zero_mask;
    int len, steps, ch, samp;
    div_val = 8'd1; chan_mask = 8'h00;
    start_code = 3'b001;
    @(negedge clk);
    measure(len, steps, ch, samp);
    chk("R7 zero mask uses channel 0", ch, 0);
    chk("R7 channel 0 flag", int'(done_flags), 1);
    rd_chan = 3'd0;
    @(negedge clk);
    chk("R7 channel 0 result", int'(rd_data), int'(stub_val(0)));
    read_clear(0);
    start_code = 3'b000;
    @(negedge clk);
  endtask

  task automatic t_trigger;
    int seen, len, steps, ch, samp;
    div_val = 8'd0; chan_mask = 8'h04; edge_fall = 1'b0;
    start_code = 3'b011;  // selects line 1
    cyc(4);
    trig_in[0] = 1'b1;    // wrong line
    seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R4 other trigger line ignored", seen, 0);
    trig_in[1] = 1'b1;
    @(negedge clk);
    chk("R4 no start after one edge", int'(busy), 0);
    @(negedge clk);
    chk("R4 no start after two edges", int'(busy), 0);
    @(negedge clk);
    chk("R4 start on third edge", int'(busy), 1);
    measure(len, steps, ch, samp);
    chk("R4 triggered channel", ch, 2);
    read_clear(2);
    // falling edge on line 5
    edge_fall = 1'b1;
    start_code = 3'b111;
    cyc(3);
    trig_in[5] = 1'b1;
    seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R4 rising edge ignored when falling selected", seen, 0);
    trig_in[5] = 1'b0;
    cyc(3);
    chk("R4 falling edge starts", int'(busy), 1);
    measure(len, steps, ch, samp);
    read_clear(2);
    start_code = 3'b000; edge_fall = 1'b0; trig_in = '0;
    cyc(4);
  endtask

  task automatic t_powerdown;
    int seen;
    div_val = 8'd0; chan_mask = 8'h01;
    pwr_down = 1'b1;
    seen = 0;
    start_code = 3'b001;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen = 1; end
    start_code = 3'b010;
    cyc(2);
    trig_in[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen = 1; end
    burst_en = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R9 no start during power-down", seen, 0);
    burst_en = 1'b0;
    start_code = 3'b000;
    @(negedge clk);
    pwr_down = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R9 no late start after release", seen, 0);
    chk("R9 no result stored", int'(done_flags), 0);
    trig_in = '0;
    cyc(4);
  endtask

  task automatic t_burst;
    int nsamp, guard, later;
    int chs[4];
    int at[4];
    div_val = 8'd1; chan_mask = 8'h26; len_code = 3'b101;
    burst_en = 1'b1;
    nsamp = 0; guard = 0;
    while (nsamp < 4 && guard < 400) begin
      @(negedge clk);
      guard++;
      if (adc_sample) begin
        chs[nsamp] = int'(adc_chan);
        at[nsamp] = guard;
        nsamp++;
      end
    end
    // fourth conversion (ch1 after wrap) is running: clear flag, stop scan
    read_clear(1);
    burst_en = 1'b0;
    chk("R6 first channel lowest set bit", chs[0], 1);
    chk("R6 second channel", chs[1], 2);
    chk("R6 third channel", chs[2], 5);
    chk("R6 wrap to lowest", chs[3], 1);
    chk("R5 back-to-back spacing 6 ticks * 2", at[1] - at[0], 12);
    later = 0; guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (adc_sample) later = 1; end
    chk("R8 no conversion after burst cleared", later, 0);
    chk("R8 running conversion stored", int'(done_flags), 8'h26);
    rd_chan = 3'd1; @(negedge clk);
    chk("R5 ch1 result right-aligned 5 bits", int'(rd_data), int'(stub_val(1) >> 5));
    rd_chan = 3'd2; @(negedge clk);
    chk("R10 ch2 own result", int'(rd_data), int'(stub_val(2) >> 5));
    rd_chan = 3'd5; @(negedge clk);
    chk("R10 ch5 own result", int'(rd_data), int'(stub_val(5) >> 5));
    read_clear(1); read_clear(2); read_clear(5);
    // shortest code: 4 ticks, 3 bits
    div_val = 8'd0; chan_mask = 8'h80; len_code = 3'b111;
    burst_en = 1'b1;
    nsamp = 0; guard = 0;
    while (nsamp < 2 && guard < 100) begin
      @(negedge clk);
      guard++;
      if (adc_sample) begin at[nsamp] = guard; chs[nsamp] = int'(adc_chan); nsamp++; end
    end
    burst_en = 1'b0;
    chk("R5 code 111 spacing 4 clocks", at[1] - at[0], 4);
    chk("R6 single-channel mask repeats", chs[1], 7);
    guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
    rd_chan = 3'd7; @(negedge clk);
    chk("R5 3-bit result", int'(rd_data), int'(stub_val(7) >> 7));
    read_clear(7);
  endtask

  initial begin
    rst_n = 1'b0; div_val = '0; chan_mask = '0; burst_en = 1'b0;
    len_code = '0; start_code = 3'b000; edge_fall = 1'b0; pwr_down = 1'b0;
    trig_in = '0; rd_en = 1'b0; rd_chan = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_software();
    t_div0();
    t_zero_mask();
    t_trigger();
    t_powerdown();
    t_burst();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule